// File: doc/BRIEF.md
# Block-Lock Write Protection Unit

This unit sits behind a serial memory front end and decides whether each committed write may proceed. It keeps the protection state: a latch that arms writes, a pin-enable bit, and a two-bit range that fences off the upper part of the array. It also times the internal programming cycle. The front end passes it write-arm and write-disarm pulses, the level of the active-low write-protect pin, and a flag that is high while the chip select frame is open. When a frame ends, the front end presents either a page commit or a status commit.

For a page commit, the front end gives the page base address and a mask of the bytes it loaded. The unit tests each byte against the locked range and returns the bytes that may be written. It then raises a busy flag for a fixed number of clocks. At the end of that time it disarms the latch, and for a status commit it loads the new protection bits. The packed status byte can be read at any time. When the pin-enable bit is set while the pin is held low, the status byte can no longer be changed, so the locked part of the array becomes read-only.

Top module: `wprot_unit`

## Requirements
- R1: The status byte `status_o` is packed as {pin-enable, 3'b000, range[1:0], arm latch, busy}, with the pin-enable bit at bit 7, the range in bits 3:2, the arm latch at bit 1 and busy at bit 0. Bits 6:4 always read 0. After reset the byte is 8'h00.
- R2: A byte at address A is locked under range 01 when A[12:11]==2'b11, under range 10 when A[12]==1, and always under range 11. Nothing is locked under range 00. On a granted page commit, `mem_commit_o` pulses one cycle after the request. `mem_byte_en_o` then equals the loaded mask with the locked bytes cleared.
- R3: While the arm latch is 0, every commit is refused. A refused commit pulses `deny_o` one cycle after the request, never raises busy and leaves the arm latch unchanged.
- R4: A status commit is refused when pin-enable is 1 and `wp_n` is 0. It is accepted when pin-enable is 0 or `wp_n` is 1.
- R5: Outside a write cycle, `wren_i` sets the arm latch and `wrdi_i` clears it, with `wrdi_i` winning if both are high. Both pulses are ignored while busy. The latch reads 0 once a write cycle completes.
- R6: A granted commit drives `busy_o` and status bit 0 high for exactly WRITE_CYCLES clocks, starting on the edge that samples the request.
- R7: Any commit that arrives while busy is refused.
- R8: A status commit changes only the pin-enable bit and the range, and it applies them on the edge that ends the write cycle. The other bits of the written byte are ignored.
- R9: If `wp_n` falls while `cs_active_i` is high, the next status commit of that frame is refused. A change on `wp_n` after a status write cycle has started does not alter the values it loads.
- R10: A page commit is refused when no byte remains enabled after the lock check. When a page commit and a status commit arrive in the same cycle, the page commit is served and the status commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Pulse that arms writes |
| wrdi_i | input | 1 | Pulse that disarms writes |
| wp_n | input | 1 | Write-protect pin level, active low |
| cs_active_i | input | 1 | High while a serial frame is open |
| arr_req_i | input | 1 | Page commit request pulse |
| arr_page_i | input | ADDR_W | Page base address |
| arr_mask_i | input | PAGE_BYTES | Bytes loaded in the page buffer |
| sr_req_i | input | 1 | Status commit request pulse |
| sr_wdata_i | input | 8 | Byte written to status |
| status_o | output | 8 | Packed status byte |
| busy_o | output | 1 | Write cycle running |
| grant_o | output | 1 | Request accepted (one cycle pulse) |
| deny_o | output | 1 | Request refused (one cycle pulse) |
| mem_commit_o | output | 1 | Page program strobe |
| mem_page_o | output | ADDR_W | Page being programmed |
| mem_byte_en_o | output | PAGE_BYTES | Bytes allowed to program |

## Verification
The bench covers the edge of each lock range: the page just below and the page at the start of each fenced region. A design that compared address bits wrongly would grant a locked page or refuse an open one. It checks that a refused commit leaves the arm latch set, and that arm and disarm pulses during a busy cycle are ignored. A design that cleared the latch on refusal, or re-armed it mid-cycle, would fail these checks. It also runs the one-way lock mode, a pin drop inside a frame before a status commit, a pin drop after the cycle has started, and a page commit that arrives together with a status commit. A design that sampled the pin late, or applied status bits at the start of the cycle, would show the wrong status byte.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [1:0] {
    FENCE_OFF     = 2'b00,
    FENCE_QUARTER = 2'b01,
    FENCE_HALF    = 2'b10,
    FENCE_FULL    = 2'b11
  } fence_e;

  // Locked test from the two most significant address bits.
  function automatic logic fence_hit(input logic [1:0] rng, input logic [1:0] top2);
    case (fence_e'(rng))
      FENCE_OFF:     fence_hit = 1'b0;
      FENCE_QUARTER: fence_hit = (top2 == 2'b11);
      FENCE_HALF:    fence_hit = top2[1];
      default:       fence_hit = 1'b1;
    endcase
  endfunction

  // Status byte packing.
  function automatic logic [7:0] pack_status(input logic pin_en, input logic [1:0] rng,
                                             input logic armed, input logic busy);
    pack_status = {pin_en, 3'b000, rng, armed, busy};
  endfunction

endpackage

// File: rtl/wprot_timer.sv
module wprot_timer #(
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic cycle_end
);
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign cycle_end = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (cycle_end) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wprot_status.sv
module wprot_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wren,
  input  logic       wrdi,
  input  logic       busy,
  input  logic       cycle_end,
  input  logic       sr_go,
  input  logic [7:0] sr_wdata,
  input  logic       cs_active,
  input  logic       wp_n,
  output logic       wel,
  output logic       wpen,
  output logic [1:0] lock_rng,
  output logic       wp_dropped
);
  logic       pend_valid;
  logic       pend_wpen;
  logic [1:0] pend_rng;
  logic       wp_q;
  logic       cs_q;
  logic       wp_fall;
  logic       frame_open;

  assign wp_fall    = cs_active && wp_q && !wp_n;
  assign frame_open = cs_active && !cs_q;

  // Arm latch: cleared at cycle end, pulses honoured only while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wel <= 1'b0;
    else if (cycle_end)       wel <= 1'b0;
    else if (!busy && wrdi)   wel <= 1'b0;
    else if (!busy && wren)   wel <= 1'b1;
  end

  // Protection bits load when the status write cycle ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_wpen  <= 1'b0;
      pend_rng   <= 2'b00;
      wpen       <= 1'b0;
      lock_rng   <= 2'b00;
    end else if (sr_go) begin
      pend_valid <= 1'b1;
      pend_wpen  <= sr_wdata[7];
      pend_rng   <= sr_wdata[3:2];
    end else if (cycle_end && pend_valid) begin
      pend_valid <= 1'b0;
      wpen       <= pend_wpen;
      lock_rng   <= pend_rng;
    end
  end

  // Pin drop inside an open frame spoils the pending status commit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q       <= 1'b1;
      cs_q       <= 1'b0;
      wp_dropped <= 1'b0;
    end else begin
      wp_q <= wp_n;
      cs_q <= cs_active;
      if (wp_fall)         wp_dropped <= 1'b1;
      else if (frame_open) wp_dropped <= 1'b0;
    end
  end
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned PAGE_BYTES = 32
) (
  input  logic                  wel,
  input  logic                  wpen,
  input  logic [1:0]            lock_rng,
  input  logic                  wp_n,
  input  logic                  wp_dropped,
  input  logic                  busy,
  input  logic                  arr_req,
  input  logic [ADDR_W-1:0]     arr_page,
  input  logic [PAGE_BYTES-1:0] arr_mask,
  input  logic                  sr_req,
  output logic                  arr_go,
  output logic                  sr_go,
  output logic [PAGE_BYTES-1:0] byte_en,
  output logic                  refuse
);
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES);

  logic pin_lock;
  logic idle_armed;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    localparam int unsigned IDX = i;
    logic [ADDR_W-1:0] byte_addr;
    assign byte_addr  = {arr_page[ADDR_W-1:OFF_W], OFF_W'(IDX)};
    assign byte_en[i] = arr_mask[i] && !fence_hit(lock_rng, byte_addr[ADDR_W-1 -: 2]);
  end

  assign pin_lock   = wpen && !wp_n;
  assign idle_armed = wel && !busy;
  assign arr_go     = arr_req && idle_armed && (|byte_en);
  assign sr_go      = sr_req && !arr_req && idle_armed && !pin_lock && !wp_dropped;
  assign refuse     = (arr_req || sr_req) && !arr_go && !sr_go;
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned PAGE_BYTES   = 32,
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wren_i,
  input  logic                  wrdi_i,
  input  logic                  wp_n,
  input  logic                  cs_active_i,
  input  logic                  arr_req_i,
  input  logic [ADDR_W-1:0]     arr_page_i,
  input  logic [PAGE_BYTES-1:0] arr_mask_i,
  input  logic                  sr_req_i,
  input  logic [7:0]            sr_wdata_i,
  output logic [7:0]            status_o,
  output logic                  busy_o,
  output logic                  grant_o,
  output logic                  deny_o,
  output logic                  mem_commit_o,
  output logic [ADDR_W-1:0]     mem_page_o,
  output logic [PAGE_BYTES-1:0] mem_byte_en_o
);
  logic                  wel;
  logic                  wpen;
  logic [1:0]            lock_rng;
  logic                  wp_dropped;
  logic                  busy;
  logic                  cycle_end;
  logic                  arr_go;
  logic                  sr_go;
  logic                  refuse;
  logic                  start;
  logic [PAGE_BYTES-1:0] byte_en;

  assign start = arr_go || sr_go;

  wprot_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_guard (
    .wel(wel), .wpen(wpen), .lock_rng(lock_rng), .wp_n(wp_n),
    .wp_dropped(wp_dropped), .busy(busy), .arr_req(arr_req_i),
    .arr_page(arr_page_i), .arr_mask(arr_mask_i), .sr_req(sr_req_i),
    .arr_go(arr_go), .sr_go(sr_go), .byte_en(byte_en), .refuse(refuse)
  );

  wprot_status u_status (
    .clk(clk), .rst_n(rst_n), .wren(wren_i), .wrdi(wrdi_i), .busy(busy),
    .cycle_end(cycle_end), .sr_go(sr_go), .sr_wdata(sr_wdata_i),
    .cs_active(cs_active_i), .wp_n(wp_n), .wel(wel), .wpen(wpen),
    .lock_rng(lock_rng), .wp_dropped(wp_dropped)
  );

  wprot_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cycle_end(cycle_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o       <= 1'b0;
      deny_o        <= 1'b0;
      mem_commit_o  <= 1'b0;
      mem_page_o    <= '0;
      mem_byte_en_o <= '0;
    end else begin
      grant_o       <= start;
      deny_o        <= refuse;
      mem_commit_o  <= arr_go;
      mem_byte_en_o <= arr_go ? byte_en : '0;
      if (arr_go) mem_page_o <= arr_page_i;
    end
  end

  assign busy_o   = busy;
  assign status_o = pack_status(wpen, lock_rng, wel, busy);
endmodule

// File: rtl/wprot_unit_chk.sv
module wprot_unit_chk #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned PAGE_BYTES = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wp_n,
  input logic [7:0]            status_o,
  input logic                  busy_o,
  input logic                  grant_o,
  input logic                  deny_o,
  input logic                  mem_commit_o,
  input logic [ADDR_W-1:0]     mem_page_o,
  input logic [PAGE_BYTES-1:0] mem_byte_en_o,
  input logic                  arr_go,
  input logic                  sr_go,
  input logic                  cycle_end,
  input logic                  wel,
  input logic                  wpen,
  input logic [1:0]            lock_rng
);
  logic page_fenced;
  assign page_fenced = (lock_rng == 2'b11)
                    || (lock_rng == 2'b10 && mem_page_o[ADDR_W-1])
                    || (lock_rng == 2'b01 && (&mem_page_o[ADDR_W-1 -: 2]));

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);

  a_r2_no_fenced_program: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit_o |-> !(page_fenced && (|mem_byte_en_o)));

  a_r3_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_go || sr_go) |-> wel);

  a_r4_pin_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sr_go |-> !(wpen && !wp_n));

  a_r5_arm_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !status_o[1]);

  a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(arr_go || sr_go));

  a_r7_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(arr_go || sr_go));

  a_r3_grant_deny_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && deny_o));
endmodule

bind wprot_unit wprot_unit_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .status_o(status_o), .busy_o(busy_o),
  .grant_o(grant_o), .deny_o(deny_o), .mem_commit_o(mem_commit_o),
  .mem_page_o(mem_page_o), .mem_byte_en_o(mem_byte_en_o), .arr_go(arr_go),
  .sr_go(sr_go), .cycle_end(cycle_end), .wel(wel), .wpen(wpen), .lock_rng(lock_rng)
);

// File: tb/wprot_unit_bench.sv
module wprot_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WC         = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wren_i = 1'b0, wrdi_i = 1'b0, wp_n = 1'b1, cs_active_i = 1'b0;
  logic        arr_req_i = 1'b0, sr_req_i = 1'b0;
  logic [12:0] arr_page_i = '0;
  logic [31:0] arr_mask_i = '0;
  logic [7:0]  sr_wdata_i = '0;
  logic [7:0]  status_o;
  logic        busy_o, grant_o, deny_o, mem_commit_o;
  logic [12:0] mem_page_o;
  logic [31:0] mem_byte_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wprot_unit #(.ADDR_W(13), .PAGE_BYTES(32), .WRITE_CYCLES(WC)) u_wprot_unit (
    .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i), .wp_n(wp_n),
    .cs_active_i(cs_active_i), .arr_req_i(arr_req_i), .arr_page_i(arr_page_i),
    .arr_mask_i(arr_mask_i), .sr_req_i(sr_req_i), .sr_wdata_i(sr_wdata_i),
    .status_o(status_o), .busy_o(busy_o), .grant_o(grant_o), .deny_o(deny_o),
    .mem_commit_o(mem_commit_o), .mem_page_o(mem_page_o), .mem_byte_en_o(mem_byte_en_o)
  );

  typedef struct packed {
    logic [1:0]  rng;
    logic [12:0] page;
    logic [31:0] mask;
    logic [31:0] exp_en;
    logic        exp_grant;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{2'b00, 13'h1FE0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    '{2'b01, 13'h17E0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    '{2'b01, 13'h1800, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{2'b10, 13'h1000, 32'h0000_00FF, 32'h0000_0000, 1'b0},
    '{2'b10, 13'h0FE0, 32'h0000_FFFF, 32'h0000_FFFF, 1'b1},
    '{2'b11, 13'h0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{2'b00, 13'h0020, 32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_wren();
    @(negedge clk) wren_i = 1'b1;
    @(negedge clk) wren_i = 1'b0;
  endtask

  task automatic pulse_wrdi();
    @(negedge clk) wrdi_i = 1'b1;
    @(negedge clk) wrdi_i = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] d, output logic g, output logic dn);
    @(negedge clk) begin sr_req_i = 1'b1; sr_wdata_i = d; end
    @(negedge clk) sr_req_i = 1'b0;
    g = grant_o; dn = deny_o;
  endtask

  task automatic arr_write(input logic [12:0] pg, input logic [31:0] m,
                           output logic g, output logic dn, output logic [31:0] en);
    @(negedge clk) begin arr_req_i = 1'b1; arr_page_i = pg; arr_mask_i = m; end
    @(negedge clk) arr_req_i = 1'b0;
    g = grant_o; dn = deny_o; en = mem_byte_en_o;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic g, dn;
    logic [31:0] en;
    int n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status_o, 8'h00);
    chk("R6 reset busy", busy_o, 1'b0);

    // Vector table: set range, arm, commit a page.
    for (int v = 0; v < 7; v++) begin
      pulse_wren();
      sr_write({4'b0000, VECS[v].rng, 2'b00}, g, dn);
      wait_idle();
      chk("R8 range loaded", status_o, {4'b0000, VECS[v].rng, 2'b00});
      pulse_wren();
      arr_write(VECS[v].page, VECS[v].mask, g, dn, en);
      chk("R2 page grant", g, VECS[v].exp_grant);
      chk("R2 byte enables", en, VECS[v].exp_en);
      chk("R10 refuse on empty", dn, !VECS[v].exp_grant);
      if (!VECS[v].exp_grant) begin
        chk("R3 arm kept after refusal", status_o[1], 1'b1);
        chk("R3 no busy after refusal", busy_o, 1'b0);
        pulse_wrdi();
      end
      wait_idle();
    end

    // Clear range back to none.
    pulse_wren();
    sr_write(8'h00, g, dn);
    wait_idle();
    chk("R5 arm clear after cycle", status_o, 8'h00);

    // Unarmed commit.
    arr_write(13'h0040, 32'h1, g, dn, en);
    chk("R3 unarmed deny", dn, 1'b1);
    chk("R3 unarmed no busy", busy_o, 1'b0);

    // WREN / WRDI ordering.
    pulse_wren();
    chk("R5 wren sets", status_o[1], 1'b1);
    pulse_wrdi();
    chk("R5 wrdi clears", status_o[1], 1'b0);
    pulse_wren();
    @(negedge clk) begin wren_i = 1'b1; wrdi_i = 1'b1; end
    @(negedge clk) begin wren_i = 1'b0; wrdi_i = 1'b0; end
    chk("R5 wrdi wins", status_o[1], 1'b0);

    // Busy length.
    pulse_wren();
    arr_write(13'h0000, 32'h1, g, dn, en);
    chk("R6 grant", g, 1'b1);
    chk("R2 commit pulse", mem_commit_o, 1'b1);
    chk("R6 status busy bit", status_o[0], 1'b1);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk("R6 busy length", n, WC);
    chk("R5 arm cleared", status_o, 8'h00);

    // Requests and arm pulses during busy.
    pulse_wren();
    arr_write(13'h0000, 32'h3, g, dn, en);
    sr_write(8'h0C, g, dn);
    chk("R7 deny while busy", dn, 1'b1);
    pulse_wren();
    wait_idle();
    chk("R5 wren ignored while busy", status_o, 8'h00);

    // Status write with junk bits; applied at end.
    pulse_wren();
    sr_write(8'hFF, g, dn);
    chk("R8 granted", g, 1'b1);
    chk("R8 not applied yet", status_o[7], 1'b0);
    wait_idle();
    chk("R8 only protection bits", status_o, 8'h8C);

    // One-way lock with pin low.
    @(negedge clk) wp_n = 1'b0;
    pulse_wren();
    sr_write(8'h00, g, dn);
    chk("R4 pin lock deny", dn, 1'b1);
    chk("R4 status unchanged", status_o, 8'h8E);
    @(negedge clk) wp_n = 1'b1;
    sr_write(8'h00, g, dn);
    chk("R4 pin high allows", g, 1'b1);
    wait_idle();
    chk("R4 unlocked status", status_o, 8'h00);

    // Pin drop inside an open frame.
    pulse_wren();
    @(negedge clk) cs_active_i = 1'b1;
    @(negedge clk) wp_n = 1'b0;
    @(negedge clk) wp_n = 1'b1;
    @(negedge clk) cs_active_i = 1'b0;
    sr_write(8'h04, g, dn);
    chk("R9 abort after pin drop", dn, 1'b1);
    @(negedge clk) cs_active_i = 1'b1;
    @(negedge clk) cs_active_i = 1'b0;
    sr_write(8'h04, g, dn);
    chk("R9 new frame allows", g, 1'b1);
    @(negedge clk) cs_active_i = 1'b1;
    @(negedge clk) wp_n = 1'b0;
    @(negedge clk) begin wp_n = 1'b1; cs_active_i = 1'b0; end
    wait_idle();
    chk("R9 started cycle unaffected", status_o, 8'h04);

    // Simultaneous page and status commits.
    @(negedge clk) cs_active_i = 1'b1;
    @(negedge clk) cs_active_i = 1'b0;
    pulse_wren();
    @(negedge clk) begin
      arr_req_i = 1'b1; arr_page_i = 13'h0000; arr_mask_i = 32'h1;
      sr_req_i = 1'b1; sr_wdata_i = 8'h0C;
    end
    @(negedge clk) begin arr_req_i = 1'b0; sr_req_i = 1'b0; end
    chk("R10 page wins", mem_commit_o, 1'b1);
    wait_idle();
    chk("R10 status dropped", status_o, 8'h04);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule